// File: doc/BRIEF.md
# Two-Axis Clock-Logic Gate Sequencer

This block runs two independent step sequencers, called X and Y. Each axis has its own clock input, modulation input, step counter, 16-bit gate mask and gate output. A small logic stage on each axis joins two input levels with AND, OR or XOR. The selected mode decides how that result is used. It can advance the step counter and drive the gate. It can drive the gate only, while the plain clock moves the counter. In the cross mode it joins the axis clock with the clock of the other axis.

The inputs are joined as levels, not as edges. The pulse widths of the incoming signals therefore shape the result. A single long clock pulse can, for example, produce several advances when a short modulation pulse repeats inside it. All four external signals are asynchronous and pass through two-flop synchronisers first. Mode, operator, length and mask are static configuration taken from the surrounding logic.

Top module: `dual_axis_gate_seq`

## Requirements
- R1: A change on any clock or modulation input first shows on the outputs three clock cycles after it is driven: two synchroniser stages plus the output register.
- R2: The operator codes are 00 = AND, 01 = OR, 10 = XOR and 11 = pass the axis clock through unchanged. Each axis has its own operator.
- R3: Mode 01 (clock-logic): the counter advances on each rising edge of op(clock, modulation). The gate follows that same combined level.
- R4: Mode 10 (gate-logic): the counter advances on each rising edge of the plain clock. The gate follows op(clock, modulation).
- R5: Mode 11 (cross): the gate follows op(own clock, other axis clock). The counter advances on each rising edge of the axis's own plain clock.
- R6: Mode 00 (plain): the counter advances on the plain clock and the gate follows the plain clock. The operator has no effect.
- R7: A length field L (0 to 15) gives a cycle of L+1 steps. When the counter advances from a step greater than or equal to L, it returns to step 0. Otherwise it adds one.
- R8: The gate output is high only when bit s of the axis mask is 1 and the gate-path level is high. Here s is the step value shown on the step output in the same cycle.
- R9: The inputs are joined as levels. Several rising edges of a combined level inside one clock pulse each advance the counter.
- R10: While the active-low reset is low, and for two cycles after it rises, both steps read 0 and both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| x_clk_i | input | 1 | X axis clock (asynchronous) |
| x_mod_i | input | 1 | X axis modulation (asynchronous) |
| y_clk_i | input | 1 | Y axis clock (asynchronous) |
| y_mod_i | input | 1 | Y axis modulation (asynchronous) |
| x_mode_i | input | 2 | X mode: 00 plain, 01 clock-logic, 10 gate-logic, 11 cross |
| y_mode_i | input | 2 | Y mode, same coding |
| x_op_i | input | 2 | X operator: 00 AND, 01 OR, 10 XOR, 11 pass clock |
| y_op_i | input | 2 | Y operator, same coding |
| x_len_i | input | 4 | X length minus one |
| y_len_i | input | 4 | Y length minus one |
| x_mask_i | input | 16 | X per-step gate mask, bit n for step n |
| y_mask_i | input | 16 | Y per-step gate mask |
| x_step_o | output | 4 | X current step |
| y_step_o | output | 4 | Y current step |
| x_gate_o | output | 1 | X gate |
| y_gate_o | output | 1 | Y gate |

## Verification
The bench builds the block with STEPS = 16 and SYNC_STAGES = 2. With these values every length from 1 to 16 can be selected. The wrap from the top mask bit, step 15, back to step 0 is reached. The three-cycle input-to-output latency is also reached, and the bench checks it directly. A behavioural model runs alongside the design and is compared every cycle. Directed pulses cover each mode, each operator, the single-step length and a long clock pulse carrying repeated modulation. A random phase then mixes all settings on both axes at once.

// File: rtl/dags_pkg.sv
package dags_pkg;

  typedef enum logic [1:0] {
    MODE_PLAIN = 2'b00,
    MODE_CLOCK = 2'b01,
    MODE_GATE  = 2'b10,
    MODE_CROSS = 2'b11
  } axis_mode_e;

  typedef enum logic [1:0] {
    OP_AND  = 2'b00,
    OP_OR   = 2'b01,
    OP_XOR  = 2'b10,
    OP_PASS = 2'b11
  } comb_op_e;

  function automatic logic combine(input comb_op_e op, input logic a, input logic b);
    logic r;
    unique case (op)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      OP_XOR:  r = a ^ b;
      default: r = a;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/dags_rst_sync.sv
module dags_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_int_n = chain_q[STAGES-1];
endmodule

// File: rtl/dags_sync.sv
module dags_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic             armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d_i;
      end
      AST_SYNC_FIRST: assert property (@(posedge clk) disable iff (!armed_q)
        stg_q[0] == $past(d_i)); // R1
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
      AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!armed_q)
        stg_q[s] == $past(stg_q[s-1])); // R1
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dags_route.sv
module dags_route
  import dags_pkg::*;
(
  input  logic [1:0] mode_i,
  input  logic [1:0] op_i,
  input  logic       clk_lvl_i,
  input  logic       mod_lvl_i,
  input  logic       other_clk_i,
  output logic       adv_o,
  output logic       gsig_o
);
  axis_mode_e mode;
  comb_op_e   op;
  logic       with_mod;
  logic       with_other;

  always_comb begin
    mode       = axis_mode_e'(mode_i);
    op         = comb_op_e'(op_i);
    with_mod   = combine(op, clk_lvl_i, mod_lvl_i);
    with_other = combine(op, clk_lvl_i, other_clk_i);
    unique case (mode)
      MODE_CLOCK: begin adv_o = with_mod;  gsig_o = with_mod;   end
      MODE_GATE:  begin adv_o = clk_lvl_i; gsig_o = with_mod;   end
      MODE_CROSS: begin adv_o = clk_lvl_i; gsig_o = with_other; end
      default:    begin adv_o = clk_lvl_i; gsig_o = clk_lvl_i;  end
    endcase
  end

  always_comb begin
    if (mode == MODE_PLAIN) AST_PLAIN_FOLLOWS_CLK: assert (gsig_o == clk_lvl_i); // R6
  end
endmodule

// File: rtl/dags_axis.sv
module dags_axis #(
  parameter int STEPS  = 16,
  localparam int STEP_W = $clog2(STEPS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STEP_W-1:0] len_i,
  input  logic [STEPS-1:0]  mask_i,
  input  logic              adv_i,
  input  logic              gsig_i,
  output logic [STEP_W-1:0] step_o,
  output logic              gate_o
);
  logic              adv_prev_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] step_d;
  logic              gate_q;
  logic              gate_d;
  logic              adv_edge;
  logic              armed_q;

  always_comb begin
    adv_edge = adv_i & ~adv_prev_q;
    step_d   = step_q;
    if (adv_edge) begin
      if (step_q >= len_i) step_d = '0;
      else                 step_d = step_q + 1'b1;
    end
    gate_d = mask_i[step_d] & gsig_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adv_prev_q <= 1'b0;
      step_q     <= '0;
      gate_q     <= 1'b0;
      armed_q    <= 1'b0;
    end else begin
      adv_prev_q <= adv_i;
      if (adv_edge) step_q <= step_d;
      gate_q     <= gate_d;
      armed_q    <= 1'b1;
    end
  end

  assign step_o = step_q;
  assign gate_o = gate_q;

  AST_STEP_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!armed_q)
    (step_q != $past(step_q)) |-> $past(adv_edge)); // R3
  AST_STEP_WRAP_OR_INC: assert property (@(posedge clk) disable iff (!armed_q)
    (step_q != $past(step_q)) |-> (step_q == $past(step_q) + 1'b1 || step_q == '0)); // R7
  AST_GATE_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!armed_q)
    gate_q |-> $past(gsig_i)); // R8
  AST_GATE_NEEDS_MASK: assert property (@(posedge clk) disable iff (!armed_q)
    gate_q |-> |($past(mask_i) & (STEPS'(1) << step_q))); // R8
endmodule

// File: rtl/dual_axis_gate_seq.sv
module dual_axis_gate_seq #(
  parameter int STEPS       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int STEP_W     = $clog2(STEPS),
  localparam int AXES       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              x_clk_i,
  input  logic              x_mod_i,
  input  logic              y_clk_i,
  input  logic              y_mod_i,
  input  logic [1:0]        x_mode_i,
  input  logic [1:0]        y_mode_i,
  input  logic [1:0]        x_op_i,
  input  logic [1:0]        y_op_i,
  input  logic [STEP_W-1:0] x_len_i,
  input  logic [STEP_W-1:0] y_len_i,
  input  logic [STEPS-1:0]  x_mask_i,
  input  logic [STEPS-1:0]  y_mask_i,
  output logic [STEP_W-1:0] x_step_o,
  output logic [STEP_W-1:0] y_step_o,
  output logic              x_gate_o,
  output logic              y_gate_o
);
  logic                  rst_int_n;
  logic [2*AXES-1:0]     raw_in;
  logic [2*AXES-1:0]     syn_in;
  logic [AXES-1:0]       clk_lvl;
  logic [AXES-1:0]       mod_lvl;
  logic [1:0]            mode_a [AXES];
  logic [1:0]            op_a   [AXES];
  logic [STEP_W-1:0]     len_a  [AXES];
  logic [STEPS-1:0]      mask_a [AXES];
  logic [STEP_W-1:0]     step_a [AXES];
  logic [AXES-1:0]       gate_a;
  logic [AXES-1:0]       adv_a;
  logic [AXES-1:0]       gsig_a;

  dags_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n)
  );

  assign raw_in = {y_mod_i, y_clk_i, x_mod_i, x_clk_i};

  dags_sync #(.WIDTH(2*AXES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d_i(raw_in), .q_o(syn_in)
  );

  always_comb begin
    mode_a[0] = x_mode_i;  mode_a[1] = y_mode_i;
    op_a[0]   = x_op_i;    op_a[1]   = y_op_i;
    len_a[0]  = x_len_i;   len_a[1]  = y_len_i;
    mask_a[0] = x_mask_i;  mask_a[1] = y_mask_i;
  end

  for (genvar a = 0; a < AXES; a++) begin : g_axis
    assign clk_lvl[a] = syn_in[2*a];
    assign mod_lvl[a] = syn_in[2*a+1];

    dags_route u_route (
      .mode_i(mode_a[a]), .op_i(op_a[a]),
      .clk_lvl_i(clk_lvl[a]), .mod_lvl_i(mod_lvl[a]),
      .other_clk_i(clk_lvl[AXES-1-a]),
      .adv_o(adv_a[a]), .gsig_o(gsig_a[a])
    );

    dags_axis #(.STEPS(STEPS)) u_axis (
      .clk(clk), .rst_n(rst_int_n),
      .len_i(len_a[a]), .mask_i(mask_a[a]),
      .adv_i(adv_a[a]), .gsig_i(gsig_a[a]),
      .step_o(step_a[a]), .gate_o(gate_a[a])
    );
  end

  assign x_step_o = step_a[0];
  assign y_step_o = step_a[1];
  assign x_gate_o = gate_a[0];
  assign y_gate_o = gate_a[1];

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_int_n |-> (x_gate_o == 1'b0 && y_gate_o == 1'b0 &&
                    x_step_o == '0 && y_step_o == '0)); // R10
endmodule

// File: tb/dual_axis_gate_seq_tb.sv
module dual_axis_gate_seq_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic x_clk, x_mod, y_clk, y_mod;
  logic [1:0] x_mode, y_mode, x_op, y_op;
  logic [3:0] x_len, y_len;
  logic [15:0] x_mask, y_mask;
  logic [3:0] x_step_o, y_step_o;
  logic x_gate_o, y_gate_o;

  dual_axis_gate_seq #(.STEPS(16), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .x_clk_i(x_clk), .x_mod_i(x_mod), .y_clk_i(y_clk), .y_mod_i(y_mod),
    .x_mode_i(x_mode), .y_mode_i(y_mode), .x_op_i(x_op), .y_op_i(y_op),
    .x_len_i(x_len), .y_len_i(y_len), .x_mask_i(x_mask), .y_mask_i(y_mask),
    .x_step_o(x_step_o), .y_step_o(y_step_o),
    .x_gate_o(x_gate_o), .y_gate_o(y_gate_o)
  );

  int total = 0;
  int bad = 0;
  string tag = "R10";
  bit finished = 0;
  bit saw_xgate = 0;

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  // behavioural reference: sync delay line as a queue per input, integer state
  int q_in [4][$];
  int m_prev [2], m_step [2], m_gate [2];
  int rc;

  function automatic int opf(input int o, input int a, input int b);
    case (o)
      0: return a & b;
      1: return a | b;
      2: return a ^ b;
      default: return a;
    endcase
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin q_in[i].delete(); q_in[i].push_back(0); q_in[i].push_back(0); end
    for (int a = 0; a < 2; a++) begin m_prev[a] = 0; m_step[a] = 0; m_gate[a] = 0; end
  endtask

  initial model_clear();

  always @(posedge clk) begin
    if (!rst_n) begin rc = 0; model_clear(); end
    else if (rc < 2) begin rc++; model_clear(); end
    else begin
      int c [2], m [2], md [2], op [2], ln [2];
      int adv, gs, edge_hit;
      logic [15:0] mk [2];
      c[0] = q_in[0][0]; m[0] = q_in[1][0]; c[1] = q_in[2][0]; m[1] = q_in[3][0];
      md[0] = x_mode; md[1] = y_mode; op[0] = x_op; op[1] = y_op;
      ln[0] = x_len; ln[1] = y_len; mk[0] = x_mask; mk[1] = y_mask;
      for (int a = 0; a < 2; a++) begin
        case (md[a])
          1: begin adv = opf(op[a], c[a], m[a]); gs = adv; end
          2: begin adv = c[a]; gs = opf(op[a], c[a], m[a]); end
          3: begin adv = c[a]; gs = opf(op[a], c[a], c[1-a]); end
          default: begin adv = c[a]; gs = c[a]; end
        endcase
        edge_hit = adv & ~m_prev[a] & 1;
        m_prev[a] = adv;
        if (edge_hit != 0) m_step[a] = (m_step[a] >= ln[a]) ? 0 : m_step[a] + 1;
        m_gate[a] = (mk[a][m_step[a]] && gs != 0) ? 1 : 0;
      end
      for (int i = 0; i < 4; i++) void'(q_in[i].pop_front());
      q_in[0].push_back(int'(x_clk)); q_in[1].push_back(int'(x_mod));
      q_in[2].push_back(int'(y_clk)); q_in[3].push_back(int'(y_mod));
    end
  end

  always @(negedge clk) begin
    if (!finished) begin
      chk(int'(x_step_o) == m_step[0], tag, "x_step", int'(x_step_o), m_step[0]);
      chk(int'(y_step_o) == m_step[1], tag, "y_step", int'(y_step_o), m_step[1]);
      chk(int'(x_gate_o) == m_gate[0], tag, "x_gate", int'(x_gate_o), m_gate[0]);
      chk(int'(y_gate_o) == m_gate[1], tag, "y_gate", int'(y_gate_o), m_gate[1]);
      if (x_gate_o) saw_xgate = 1;
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xpulse(input int hi, input int lo);
    x_clk = 1; cyc(hi); x_clk = 0; cyc(lo);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      chk(0, "WATCHDOG", "timeout", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1; x_clk = 0; x_mod = 0; y_clk = 0; y_mod = 0;
    x_mode = 0; y_mode = 0; x_op = 0; y_op = 0;
    x_len = 3; y_len = 3; x_mask = 16'hFFFF; y_mask = 16'hFFFF;
    #1 rst_n = 0;
    cyc(3);
    x_clk = 1; y_clk = 1;
    cyc(2);
    chk(x_step_o == 0 && x_gate_o == 0, "R10", "x in reset", int'(x_gate_o), 0);
    rst_n = 1; x_clk = 0; y_clk = 0;
    cyc(1);
    chk(y_step_o == 0 && y_gate_o == 0, "R10", "y after release", int'(y_gate_o), 0);
    cyc(4);

    // R1 latency
    tag = "R1";
    x_clk = 1;
    cyc(2);
    chk(x_gate_o == 0, "R1", "gate before 3 cycles", int'(x_gate_o), 0);
    cyc(1);
    chk(x_gate_o == 1, "R1", "gate at 3 cycles", int'(x_gate_o), 1);
    x_clk = 0; cyc(4);

    // R6 plain mode, operator ignored
    tag = "R6";
    x_op = 2'b00; x_mod = 0;
    base = int'(x_step_o);
    for (int i = 0; i < 6; i++) xpulse(2, 2);
    cyc(3);
    chk(int'(x_step_o) == (base + 6) % 4, "R6", "plain step", int'(x_step_o), (base + 6) % 4);

    // R7 single-step length
    tag = "R7";
    x_len = 0;
    for (int i = 0; i < 3; i++) xpulse(2, 2);
    cyc(3);
    chk(x_step_o == 0, "R7", "len0 step", int'(x_step_o), 0);
    x_len = 15;
    for (int i = 0; i < 17; i++) xpulse(1, 2);
    cyc(3);
    chk(x_step_o == 1, "R7", "len16 wrap", int'(x_step_o), 1);

    // R3 clock-logic AND with mod low: no advance
    tag = "R3";
    x_mode = 2'b01; x_op = 2'b00; x_mod = 0;
    base = int'(x_step_o);
    for (int i = 0; i < 4; i++) xpulse(2, 2);
    cyc(3);
    chk(int'(x_step_o) == base, "R3", "held step", int'(x_step_o), base);
    x_mod = 1; cyc(3);
    for (int i = 0; i < 3; i++) xpulse(2, 2);
    cyc(3);
    chk(int'(x_step_o) == base + 3, "R3", "and step", int'(x_step_o), base + 3);
    x_mod = 0; cyc(3);

    // R9 repeated mod inside one long clock pulse
    tag = "R9";
    base = int'(x_step_o);
    x_clk = 1; cyc(2);
    x_mod = 1; cyc(2); x_mod = 0; cyc(2);
    x_mod = 1; cyc(2); x_mod = 0; cyc(2);
    x_clk = 0; cyc(4);
    chk(int'(x_step_o) == base + 2, "R9", "level steps", int'(x_step_o), base + 2);

    // R4 gate-logic AND, mod low: advance, no gate
    tag = "R4";
    x_mode = 2'b10; cyc(3); saw_xgate = 0;
    base = int'(x_step_o);
    for (int i = 0; i < 5; i++) xpulse(2, 2);
    cyc(3);
    chk(int'(x_step_o) == (base + 5) % 16, "R4", "gate-logic step", int'(x_step_o), (base + 5) % 16);
    chk(saw_xgate == 0, "R4", "gate stayed low", int'(saw_xgate), 0);

    // R5 cross mode, y clock as operand
    tag = "R5";
    x_mode = 2'b11; y_clk = 0; cyc(3); saw_xgate = 0;
    base = int'(x_step_o);
    for (int i = 0; i < 3; i++) xpulse(2, 2);
    cyc(3);
    chk(saw_xgate == 0, "R5", "cross gate low", int'(saw_xgate), 0);
    chk(int'(x_step_o) == (base + 3) % 16, "R5", "cross step", int'(x_step_o), (base + 3) % 16);
    y_clk = 1; cyc(3); saw_xgate = 0;
    xpulse(3, 3);
    chk(saw_xgate == 1, "R5", "cross gate high", int'(saw_xgate), 1);
    y_clk = 0; cyc(3);

    // R2 pass-through and XOR
    tag = "R2";
    x_mode = 2'b01; x_op = 2'b11; x_mod = 0; cyc(3);
    base = int'(x_step_o);
    for (int i = 0; i < 2; i++) xpulse(2, 2);
    cyc(3);
    chk(int'(x_step_o) == (base + 2) % 16, "R2", "pass step", int'(x_step_o), (base + 2) % 16);
    x_op = 2'b10;
    for (int i = 0; i < 4; i++) begin x_mod = ~x_mod; xpulse(2, 3); end

    // R8 random mix checked against the model every cycle
    tag = "R8";
    for (int blk = 0; blk < 20; blk++) begin
      x_mode = 2'($urandom_range(0, 3)); y_mode = 2'($urandom_range(0, 3));
      x_op = 2'($urandom_range(0, 3));   y_op = 2'($urandom_range(0, 3));
      x_len = 4'($urandom_range(0, 15)); y_len = 4'($urandom_range(0, 15));
      x_mask = 16'($urandom); y_mask = 16'($urandom);
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if ($urandom_range(0, 3) == 0) x_clk = ~x_clk;
        if ($urandom_range(0, 4) == 0) y_clk = ~y_clk;
        if ($urandom_range(0, 2) == 0) x_mod = ~x_mod;
        if ($urandom_range(0, 5) == 0) y_mod = ~y_mod;
      end
    end
    cyc(4);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule